// File: doc/BRIEF.md
# Dual-Reset JK Flip-Flop Pair

This block places two JK flip-flops side by side. Both receive the same J, K, reset and clock. They differ only in how reset acts: one clears on a rising clock edge while reset is high, the other clears the moment reset goes high. The difference between the two outputs shows that timing difference. Each JK cell is built in layers. A toggle flip-flop is the storage element. A D flip-flop is formed from it by driving the toggle input with the D input XOR the current output. A next-state selector in front of the D input produces the JK function.

A counter-based divider produces a one-cycle enable pulse every `DIV_COUNT` clock edges. The pulse gates every state update, so the design has only one clock and the changes can be slowed enough to watch on hardware. With `DIV_COUNT = 1` the enable is always high and every edge is active. Reset is active high and clears both outputs to 0.

Top module: `dual_reset_jk`

## Requirements
- R1: State changes only at a rising clock edge on which the divider enable is high; a J/K change between edges leaves both outputs unchanged until that edge.
- R2: J=0, K=0 on an active edge holds the current output.
- R3: J=0, K=1 on an active edge drives the output to 0.
- R4: J=1, K=0 on an active edge drives the output to 1.
- R5: J=1, K=1 on an active edge inverts the output.
- R6: `q_async` becomes 0 as soon as `rst` rises, without waiting for a clock edge.
- R7: `q_sync` keeps its value after `rst` rises and becomes 0 only at the first rising edge on which `rst` is high, whatever the divider enable is.
- R8: While `rst` stays high across an edge, both outputs are 0. Outside reset the two outputs are equal.
- R9: After reset is released, the divider enable is high on every `DIV_COUNT`-th edge, starting with edge number `DIV_COUNT`. No J/K command acts on any other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Active-high reset shared by both cells and the divider |
| j | input | 1 | J input shared by both cells |
| k | input | 1 | K input shared by both cells |
| q_sync | output | 1 | Output of the cell with synchronous reset |
| q_async | output | 1 | Output of the cell with asynchronous reset |

## Verification
The bench raises reset just after a clock edge while both outputs are 1. It then samples inside that same cycle. A design with the reset types swapped, or with both cells wired the same way, shows `q_async` still at 1 or `q_sync` already at 0 at that point. The bench walks all four J/K commands from both output values and applies consecutive toggles. A wrong selector, or a D-from-toggle conversion with the XOR missing, shows up as a held or doubled inversion. A second instance with a divide-by-three count checks that commands act only on every third edge. A counter that is off by one moves the set and the toggle by one edge.

// File: rtl/dual_jk_pkg.sv
package dual_jk_pkg;

  typedef enum logic [1:0] {
    JK_HOLD   = 2'b00,
    JK_CLEAR  = 2'b01,
    JK_SET    = 2'b10,
    JK_TOGGLE = 2'b11
  } jk_cmd_e;

  // Next state of a JK cell from its command and present state.
  function automatic logic jk_next(input logic j, input logic k, input logic q);
    jk_cmd_e cmd;
    cmd = jk_cmd_e'({j, k});
    case (cmd)
      JK_HOLD:   return q;
      JK_CLEAR:  return 1'b0;
      JK_SET:    return 1'b1;
      default:   return ~q;
    endcase
  endfunction

  // Toggle request that makes a toggle element follow a D value.
  function automatic logic d_to_toggle(input logic d, input logic q);
    return d ^ q;
  endfunction

endpackage

// File: rtl/toggle_cell.sv
module toggle_cell #(
  parameter bit ASYNC_RST = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic t,
  output logic q
);

  logic flip;
  assign flip = en & t;

  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or posedge rst) begin
        if (rst)       q <= 1'b0;
        else if (flip) q <= ~q;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (flip) q <= ~q;
      end
    end
  endgenerate

endmodule

// File: rtl/d_from_toggle.sv
module d_from_toggle #(
  parameter bit ASYNC_RST = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic q
);
  import dual_jk_pkg::*;

  logic t_req;
  assign t_req = d_to_toggle(d, q);

  toggle_cell #(.ASYNC_RST(ASYNC_RST)) u_tff (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .t   (t_req),
    .q   (q)
  );

endmodule

// File: rtl/jk_cell.sv
module jk_cell #(
  parameter bit ASYNC_RST = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic j,
  input  logic k,
  output logic q
);
  import dual_jk_pkg::*;

  logic d_sel;
  assign d_sel = jk_next(j, k, q);

  d_from_toggle #(.ASYNC_RST(ASYNC_RST)) u_dff (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .d   (d_sel),
    .q   (q)
  );

endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DIV_COUNT = 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam int CNT_W = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_COUNT - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/dual_reset_jk.sv
module dual_reset_jk #(
  parameter int DIV_COUNT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q_sync,
  output logic q_async
);

  logic tick;

  tick_divider #(.DIV_COUNT(DIV_COUNT)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  jk_cell #(.ASYNC_RST(1'b0)) u_jk_sync (
    .clk (clk),
    .rst (rst),
    .en  (tick),
    .j   (j),
    .k   (k),
    .q   (q_sync)
  );

  jk_cell #(.ASYNC_RST(1'b1)) u_jk_async (
    .clk (clk),
    .rst (rst),
    .en  (tick),
    .j   (j),
    .k   (k),
    .q   (q_async)
  );

endmodule

// File: rtl/dual_reset_jk_checker.sv
module dual_reset_jk_checker (
  input logic clk,
  input logic rst,
  input logic j,
  input logic k,
  input logic tick,
  input logic q_sync,
  input logic q_async
);

  logic rst_at_edge;
  always_ff @(posedge clk) rst_at_edge <= rst;

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(q_sync) && $stable(q_async)))
    else $error("R1 state moved without enable");

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (tick && !j && !k) |=> ($stable(q_sync) && $stable(q_async)))
    else $error("R2 hold failed");

  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    (tick && !j && k) |=> (!q_sync && !q_async))
    else $error("R3 clear failed");

  a_r4_set: assert property (@(posedge clk) disable iff (rst)
    (tick && j && !k) |=> (q_sync && q_async))
    else $error("R4 set failed");

  a_r5_toggle: assert property (@(posedge clk) disable iff (rst)
    (tick && j && k) |=> (q_sync != $past(q_sync)))
    else $error("R5 toggle failed");

  a_r8_match: assert property (@(posedge clk) disable iff (rst)
    q_sync == q_async)
    else $error("R8 outputs disagree outside reset");

  always @(negedge clk) begin
    if (rst) begin
      a_r6_async_clear: assert (!q_async) else $error("R6 async output not cleared");
    end
    if (rst_at_edge === 1'b1) begin
      a_r7_sync_clear: assert (!q_sync) else $error("R7 sync output not cleared at edge");
    end
  end

endmodule

bind dual_reset_jk dual_reset_jk_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .j       (j),
  .k       (k),
  .tick    (tick),
  .q_sync  (q_sync),
  .q_async (q_async)
);

// File: tb/dual_reset_jk_bench.sv
module dual_reset_jk_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic j = 1'b0;
  logic k = 1'b0;
  logic q_sync, q_async, dq_sync, dq_async;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_reset_jk u_dual_reset_jk (
    .clk(clk), .rst(rst), .j(j), .k(k), .q_sync(q_sync), .q_async(q_async)
  );

  dual_reset_jk #(.DIV_COUNT(3)) u_dual_reset_jk_div3 (
    .clk(clk), .rst(rst), .j(j), .k(k), .q_sync(dq_sync), .q_async(dq_async)
  );

  // {j, k, expected q}
  localparam logic [2:0] VEC [10] = '{
    3'b00_0, 3'b01_0, 3'b11_1, 3'b00_1, 3'b10_1,
    3'b01_0, 3'b10_1, 3'b11_0, 3'b11_1, 3'b01_0
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic jv, input logic kv);
    @(negedge clk);
    j = jv;
    k = kv;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R8 reset q_sync", q_sync, 1'b0);
    check("R8 reset q_async", q_async, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R2 R3 R4 R5: every command from both start values
    for (int i = 0; i < 10; i++) begin
      step(VEC[i][2], VEC[i][1]);
      check($sformatf("R2-5 vec%0d q_sync", i), q_sync, VEC[i][0]);
      check($sformatf("R2-5 vec%0d q_async", i), q_async, VEC[i][0]);
    end

    // R1: input change between edges has no effect until the edge
    @(negedge clk);
    j = 1'b1;
    k = 1'b0;
    #2;
    check("R1 mid-cycle q_sync", q_sync, 1'b0);
    check("R1 mid-cycle q_async", q_async, 1'b0);
    @(posedge clk);
    #1;
    check("R1 after edge q_sync", q_sync, 1'b1);
    check("R1 after edge q_async", q_async, 1'b1);

    // R6 R7: reset raised just after an edge
    #1;
    rst = 1'b1;
    #1;
    check("R6 async cleared before edge", q_async, 1'b0);
    check("R7 sync held before edge", q_sync, 1'b1);
    @(posedge clk);
    #1;
    check("R7 sync cleared at edge", q_sync, 1'b0);
    @(posedge clk);
    #1;
    check("R8 held reset q_sync", q_sync, 1'b0);
    check("R8 held reset q_async", q_async, 1'b0);
    step(1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R8 release match", q_sync, q_async);
    check("R8 release q_sync", q_sync, 1'b0);

    // R9: divide-by-three instance, fresh reset
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    j = 1'b1;
    k = 1'b0;
    @(posedge clk); #1;
    check("R9 div edge1 q_sync", dq_sync, 1'b0);
    @(posedge clk); #1;
    check("R9 div edge2 q_async", dq_async, 1'b0);
    @(posedge clk); #1;
    check("R9 div edge3 q_sync", dq_sync, 1'b1);
    check("R9 div edge3 q_async", dq_async, 1'b1);
    @(negedge clk);
    j = 1'b1;
    k = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check("R9 div edge5 hold", dq_sync, 1'b1);
    @(posedge clk); #1;
    check("R9 div edge6 toggle q_sync", dq_sync, 1'b0);
    check("R9 div edge6 toggle q_async", dq_async, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule